// File: doc/BRIEF.md
# Link Health Supervisor

The supervisor watches the status of a 10G serial link and drives its recovery. Two status flags come from the PCS: a link-up indication and a lane-alignment indication. The supervisor reports the link as up only while both are true together. When either one drops during normal monitoring, it starts a recovery procedure.

The procedure has two nested loops. Each outer attempt issues a one-cycle link-reset request. The supervisor then waits a programmable delay and samples both flags, and it repeats that wait-and-sample step up to an inner budget. When the inner budget is used up without a good sample, a new reset request is issued, up to an outer budget. The procedure ends with a one-cycle done pulse and a pass/fail result, and monitoring resumes.

The block also judges link quality from two free-running fault counters, one for local faults and one for remote faults. On every periodic check strobe it compares each counter with the value it stored at the previous strobe. It raises a bad-link flag when either counter has advanced by more than a threshold. This check only produces a flag while an enable input is set.

Top module: `link_health_sup`

## Requirements
- R1: `linkUp` rises only in the cycle after a clock edge at which `statUp` and `laneAligned` were both 1. While monitoring with both flags at 1, `linkUp` stays 1.
- R2: While monitoring, if either `statUp` or `laneAligned` is 0 at a clock edge, then in the next cycle `linkUp` is 0 and `linkResetReq` is 1 for exactly one cycle.
- R3: Counting the reset-request cycle as cycle 0, the flags are sampled at the end of cycles DELAY_CYC+1, 2*(DELAY_CYC+1) and so on, up to WAIT_TRIES samples per reset request.
- R4: If all WAIT_TRIES samples of an attempt fail, the next reset request comes in the cycle right after the last sample. At most OUTER_TRIES requests are issued per procedure.
- R5: The procedure ends at the first sample that sees both flags at 1. `recoverDone` is then 1 for one cycle in the next cycle, with `recoverPass`=1 and `linkUp`=1.
- R6: If every sample of every attempt fails, `recoverDone` pulses with `recoverPass`=0 and `linkUp`=0 in the cycle after the last sample. Monitoring then resumes: with both flags at 1 in that cycle, `linkUp` is 1 one cycle later.
- R7: On a cycle with `checkStrobe`=1 and `faultCheckEn`=1, `badLink` becomes 1 in the next cycle if (local count − stored local) mod 2^32 or (remote count − stored remote) mod 2^32 exceeds THRESH (250). Otherwise it becomes 0. `badLink` holds its value between strobes.
- R8: A delta of exactly THRESH does not flag, and a delta of THRESH+1 does. A counter that wraps past 2^32 is measured by modular difference.
- R9: Both stored samples take the current counts at every strobe, whether or not a flag was raised and whatever `faultCheckEn` is.
- R10: A strobe with `faultCheckEn`=0 makes `badLink` 0 in the next cycle, whatever the deltas.
- R11: While `rstN` is 0, `linkUp`, `linkResetReq`, `recoverDone`, `recoverPass` and `badLink` are all 0. Both stored samples reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| statUp | input | 1 | Link-up status from the PCS |
| laneAligned | input | 1 | Lane-alignment status from the PCS |
| checkStrobe | input | 1 | Periodic health-check strobe |
| faultCheckEn | input | 1 | Enables bad-link judgement |
| localFaultCnt | input | 32 | Free-running local-fault counter |
| remoteFaultCnt | input | 32 | Free-running remote-fault counter |
| linkUp | output | 1 | Qualified link-up result |
| linkResetReq | output | 1 | One-cycle link-reset request |
| recoverDone | output | 1 | One-cycle pulse at the end of a recovery procedure |
| recoverPass | output | 1 | Result of the last recovery, 1 for link up |
| badLink | output | 1 | Fault-count delta exceeded threshold at last strobe |

## Verification
The hardest case to reach from the ports is a recovery whose flags come good exactly on, just before or just after a particular inner or outer sample. The sample cycles are not visible at the ports. The bench counts cycles from each observed reset request and raises both flags at a randomly chosen offset, covering the full procedure and past it. It predicts the sample that first sees them, and from that the number of reset requests, the done cycle and the result. The wrap and exact-threshold fault cases are driven directly, and so is a disabled strobe followed by an enabled one, which shows that the stored samples advance.

// File: rtl/lhs_pkg.sv
package lhs_pkg;
  typedef enum logic [1:0] {
    ST_MON,
    ST_RST,
    ST_WAIT,
    ST_CHK
  } supState_t;

  typedef struct packed {
    logic ldOuter;
    logic decOuter;
    logic ldWait;
    logic decWait;
    logic ldDelay;
    logic decDelay;
  } ctrlStrobes_t;
endpackage

// File: rtl/lhs_datapath.sv
module lhs_datapath
  import lhs_pkg::*;
#(
  parameter int DELAY_CYC   = 4,
  parameter int WAIT_TRIES  = 3,
  parameter int OUTER_TRIES = 2,
  parameter int CNT_W       = 32,
  parameter int THRESH      = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  output logic             delayZero,
  output logic             waitLast,
  output logic             outerLast,
  input  logic             checkStrobe,
  input  logic             faultCheckEn,
  input  logic [CNT_W-1:0] localFaultCnt,
  input  logic [CNT_W-1:0] remoteFaultCnt,
  output logic             badLink
);
  localparam int DW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam int WW = $clog2(WAIT_TRIES + 1);
  localparam int OW = $clog2(OUTER_TRIES + 1);
  localparam logic [CNT_W-1:0] TH = CNT_W'(THRESH);

  logic [DW-1:0] delayCnt;
  logic [WW-1:0] waitCnt;
  logic [OW-1:0] outerCnt;
  logic [CNT_W-1:0] prevLocal, prevRemote;
  logic [CNT_W-1:0] deltaLocal, deltaRemote;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCnt <= '0;
      waitCnt  <= '0;
      outerCnt <= '0;
    end else begin
      if (strobes.ldDelay)       delayCnt <= DW'(DELAY_CYC - 1);
      else if (strobes.decDelay) delayCnt <= delayCnt - 1'b1;
      if (strobes.ldWait)        waitCnt <= WW'(WAIT_TRIES);
      else if (strobes.decWait)  waitCnt <= waitCnt - 1'b1;
      if (strobes.ldOuter)       outerCnt <= OW'(OUTER_TRIES);
      else if (strobes.decOuter) outerCnt <= outerCnt - 1'b1;
    end
  end

  assign delayZero = (delayCnt == '0);
  assign waitLast  = (waitCnt == WW'(1));
  assign outerLast = (outerCnt == OW'(1));

  // modular difference absorbs counter wrap
  assign deltaLocal  = localFaultCnt - prevLocal;
  assign deltaRemote = remoteFaultCnt - prevRemote;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLocal  <= '0;
      prevRemote <= '0;
      badLink    <= 1'b0;
    end else if (checkStrobe) begin
      prevLocal  <= localFaultCnt;
      prevRemote <= remoteFaultCnt;
      badLink    <= faultCheckEn && ((deltaLocal > TH) || (deltaRemote > TH));
    end
  end

  p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= WW'(WAIT_TRIES));
  p_outer_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    outerCnt <= OW'(OUTER_TRIES));
  p_bad_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !checkStrobe |=> $stable(badLink));
  p_bad_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (checkStrobe && !faultCheckEn) |=> !badLink);
endmodule

// File: rtl/lhs_ctrl.sv
module lhs_ctrl
  import lhs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         statUp,
  input  logic         laneAligned,
  input  logic         delayZero,
  input  logic         waitLast,
  input  logic         outerLast,
  output ctrlStrobes_t strobes,
  output logic         linkUp,
  output logic         linkResetReq,
  output logic         recoverDone,
  output logic         recoverPass
);
  supState_t state, nextState;
  logic bothGood;

  assign bothGood = statUp && laneAligned;

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_MON: if (!bothGood) begin
        nextState       = ST_RST;
        strobes.ldOuter = 1'b1;
      end
      ST_RST: begin
        nextState       = ST_WAIT;
        strobes.ldWait  = 1'b1;
        strobes.ldDelay = 1'b1;
      end
      ST_WAIT: if (delayZero) nextState = ST_CHK;
               else strobes.decDelay = 1'b1;
      ST_CHK: begin
        if (bothGood) nextState = ST_MON;
        else if (!waitLast) begin
          nextState       = ST_WAIT;
          strobes.decWait = 1'b1;
          strobes.ldDelay = 1'b1;
        end else if (!outerLast) begin
          nextState        = ST_RST;
          strobes.decOuter = 1'b1;
        end else nextState = ST_MON;
      end
      default: nextState = ST_MON;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_MON;
      linkUp      <= 1'b0;
      recoverDone <= 1'b0;
      recoverPass <= 1'b0;
    end else begin
      state       <= nextState;
      recoverDone <= 1'b0;
      case (state)
        ST_MON: linkUp <= bothGood;
        ST_CHK: begin
          linkUp <= bothGood;
          if (bothGood || (waitLast && outerLast)) begin
            recoverDone <= 1'b1;
            recoverPass <= bothGood;
          end
        end
        default: linkUp <= 1'b0;
      endcase
    end
  end

  assign linkResetReq = (state == ST_RST);

  p_up_needs_both_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkUp) |-> $past(statUp && laneAligned));
  p_req_after_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MON && !bothGood) |=> (linkResetReq && !linkUp));
  p_req_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    linkResetReq |=> !linkResetReq);
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    recoverDone |=> !recoverDone);
  p_pass_up_r5: assert property (@(posedge clk) disable iff (!rstN)
    recoverDone |-> (recoverPass == linkUp));
endmodule

// File: rtl/link_health_sup.sv
module link_health_sup
  import lhs_pkg::*;
#(
  parameter int DELAY_CYC   = 4,
  parameter int WAIT_TRIES  = 3,
  parameter int OUTER_TRIES = 2,
  parameter int CNT_W       = 32,
  parameter int THRESH      = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             statUp,
  input  logic             laneAligned,
  input  logic             checkStrobe,
  input  logic             faultCheckEn,
  input  logic [CNT_W-1:0] localFaultCnt,
  input  logic [CNT_W-1:0] remoteFaultCnt,
  output logic             linkUp,
  output logic             linkResetReq,
  output logic             recoverDone,
  output logic             recoverPass,
  output logic             badLink
);
  ctrlStrobes_t strobes;
  logic delayZero, waitLast, outerLast;

  lhs_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .statUp(statUp), .laneAligned(laneAligned),
    .delayZero(delayZero), .waitLast(waitLast), .outerLast(outerLast),
    .strobes(strobes), .linkUp(linkUp), .linkResetReq(linkResetReq),
    .recoverDone(recoverDone), .recoverPass(recoverPass)
  );

  lhs_datapath #(
    .DELAY_CYC(DELAY_CYC), .WAIT_TRIES(WAIT_TRIES), .OUTER_TRIES(OUTER_TRIES),
    .CNT_W(CNT_W), .THRESH(THRESH)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .delayZero(delayZero),
    .waitLast(waitLast), .outerLast(outerLast), .checkStrobe(checkStrobe),
    .faultCheckEn(faultCheckEn), .localFaultCnt(localFaultCnt),
    .remoteFaultCnt(remoteFaultCnt), .badLink(badLink)
  );
endmodule

// File: tb/test_link_health_sup.sv
module test_link_health_sup;
  localparam int CLK_PERIOD = 10;
  localparam int D = 4;
  localparam int W = 3;
  localparam int O = 2;
  localparam int TH = 250;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic statUp = 1'b1, laneAligned = 1'b1;
  logic checkStrobe = 1'b0, faultCheckEn = 1'b1;
  logic [31:0] localFaultCnt = '0, remoteFaultCnt = '0;
  logic linkUp, linkResetReq, recoverDone, recoverPass, badLink;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] prevL = '0, prevR = '0;

  link_health_sup #(.DELAY_CYC(D), .WAIT_TRIES(W), .OUTER_TRIES(O),
                    .CNT_W(32), .THRESH(TH)) i_link_health_sup (
    .clk(clk), .rstN(rstN), .statUp(statUp), .laneAligned(laneAligned),
    .checkStrobe(checkStrobe), .faultCheckEn(faultCheckEn),
    .localFaultCnt(localFaultCnt), .remoteFaultCnt(remoteFaultCnt),
    .linkUp(linkUp), .linkResetReq(linkResetReq), .recoverDone(recoverDone),
    .recoverPass(recoverPass), .badLink(badLink)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors = vectors + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic expBad(input logic en, input logic [31:0] l,
                                  input logic [31:0] r, input logic [31:0] pl,
                                  input logic [31:0] pr);
    logic [31:0] dl, dr;
    dl = l - pl;
    dr = r - pr;
    return en && ((dl > 32'(TH)) || (dr > 32'(TH)));
  endfunction

  // first sample cycle >= g, relative to the first reset request; -1 if none
  function automatic int firstGoodSample(input int g, output int attempts);
    for (int o = 0; o < O; o++)
      for (int j = 0; j < W; j++) begin
        int c;
        c = o * (1 + W * (D + 1)) + (j + 1) * (D + 1);
        if (c >= g) begin
          attempts = o + 1;
          return c;
        end
      end
    attempts = O;
    return -1;
  endfunction

  task automatic faultStrobe(input logic en, input logic [31:0] l,
                             input logic [31:0] r, input string req);
    logic e;
    e = expBad(en, l, r, prevL, prevR);
    faultCheckEn = en;
    localFaultCnt = l;
    remoteFaultCnt = r;
    checkStrobe = 1'b1;
    @(negedge clk);
    checkStrobe = 1'b0;
    prevL = l;
    prevR = r;
    check(req, int'(badLink), int'(e));
    @(negedge clk);
    check({req, " hold R7"}, int'(badLink), int'(e));
  endtask

  task automatic recovery(input int g, input bit dropAlign);
    int expAtt, sampleCyc, rel, pulses, doneRel;
    logic passSeen, upSeen;
    sampleCyc = firstGoodSample(g, expAtt);
    if (dropAlign) laneAligned = 1'b0; else statUp = 1'b0;
    @(negedge clk);
    check("R2 linkUp low after drop", int'(linkUp), 0);
    check("R2 reset request after drop", int'(linkResetReq), 1);
    rel = 0; pulses = 1; doneRel = -1; passSeen = 1'b0; upSeen = 1'b0;
    while (doneRel < 0 && rel < 80) begin
      @(negedge clk);
      rel++;
      if (linkResetReq) pulses++;
      if (recoverDone) begin
        doneRel = rel; passSeen = recoverPass; upSeen = linkUp;
      end
      if (rel >= g || recoverDone) begin
        statUp = 1'b1; laneAligned = 1'b1;
      end
    end
    if (sampleCyc >= 0) begin
      check("R5 done cycle", doneRel, sampleCyc + 1);
      check("R5 pass result", int'(passSeen), 1);
      check("R5 linkUp at done", int'(upSeen), 1);
      check("R4 reset requests", pulses, expAtt);
      @(negedge clk);
      check("R1 linkUp held", int'(linkUp), 1);
    end else begin
      check("R6 done cycle", doneRel, O * (1 + W * (D + 1)));
      check("R6 fail result", int'(passSeen), 0);
      check("R6 linkUp at fail", int'(upSeen), 0);
      check("R4 reset requests", pulses, O);
      @(negedge clk);
      check("R6 linkUp after resume", int'(linkUp), 1);
    end
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    check("R11 linkUp in reset", int'(linkUp), 0);
    check("R11 resetReq in reset", int'(linkResetReq), 0);
    check("R11 done in reset", int'(recoverDone), 0);
    check("R11 pass in reset", int'(recoverPass), 0);
    check("R11 badLink in reset", int'(badLink), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 linkUp with both flags", int'(linkUp), 1);

    // fault-delta corner cases
    faultStrobe(1'b1, 32'd250, 32'd0, "R8 delta equal threshold");
    faultStrobe(1'b1, 32'd501, 32'd0, "R8 delta threshold plus one");
    faultStrobe(1'b1, 32'd501, 32'd752, "R7 remote delta");
    faultStrobe(1'b1, 32'hFFFF_FF80, 32'd752, "R7 setup");
    faultStrobe(1'b1, 32'h0000_0010, 32'd752, "R8 wrap delta 144");
    faultStrobe(1'b1, 32'h0000_0111, 32'd752, "R8 delta 257");
    faultStrobe(1'b0, 32'h0001_0000, 32'h0010_0000, "R10 disabled large delta");
    faultStrobe(1'b1, 32'h0001_0005, 32'h0010_0005, "R9 samples advanced");
    for (int i = 0; i < 40; i++) begin
      logic [31:0] dl, dr;
      dl = ($urandom_range(0, 3) == 0) ? 32'(TH + $urandom_range(0, 2) - 1)
                                       : 32'($urandom_range(0, 400));
      dr = 32'($urandom_range(0, 300));
      faultStrobe(($urandom_range(0, 4) != 0), prevL + dl, prevR + dr, "R7 random");
    end

    // directed recovery edges: sample instants of attempt 1 and 2, beyond budget
    recovery(5, 1'b1);
    recovery(6, 1'b0);
    recovery(15, 1'b1);
    recovery(16, 1'b0);
    recovery(31, 1'b1);
    recovery(32, 1'b0);
    recovery(60, 1'b1);
    for (int i = 0; i < 16; i++)
      recovery($urandom_range(1, 40), 1'($urandom_range(0, 1)));

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule